// File: doc/BRIEF.md
# Idle Standby Wake Controller

This block runs the idle low-power state of a small processor subsystem. Software asks for idle through a two-address register write port. It first clears a standby-depth select bit, then sets a stop bit. The controller then passes through a short entry phase and switches off the CPU clock enable and the main-domain peripheral clock enable. The oscillator-running output and the enable for peripherals on secondary clocks stay on throughout.

While idle, the block watches the wake sources:

- a non-maskable pin;
- a non-maskable watchdog request;
- eight external interrupt pins, each with its own mask;
- a group of internal peripheral requests, each with its own mask.

Three disable bits can stop either non-maskable source, or the whole maskable group, from ending idle. Every enabled wake source returns the block to normal operation on one clock edge, with no stabilization wait, and clears the stop bit.

On each wake the block tells the interrupt logic whether to acknowledge the waking request or leave it pending. It makes this decision from the interrupt-enable state, the in-service priority and the pending priority. A watchdog reset request input has no effect on the block.

Top module: `idle_wake_ctrl`

## Requirements
- R1: During reset and after it, state_o is 3'b001 (normal), cpu_clk_en_o, per_clk_en_o, osc_run_o and aux_clk_en_o are 1, and wake_o, wake_ack_o and wake_nmi_o are 0. Asserting rst_n while idle returns the block to this state at once.
- R2: Idle entry takes a write to address 1 with wr_data bit 0 set, made in normal state while the mode bit is 0. state_o goes to 3'b010 (entering) on the second rising edge counted from the write edge, which is edge 1. It goes to 3'b100 (idle) on edge 4, which is within five edges.
- R3: A stop write made while the mode bit (address 0, wr_data bit 0) is 1 is ignored, and state_o stays at 3'b001.
- R4: In idle, cpu_clk_en_o and per_clk_en_o are 0, while osc_run_o and aux_clk_en_o stay at 1. Both gated enables are 1 in every other state.
- R5: nmi_pin and ext_irq pass through two synchronizing flops. A pin raised before edge 1 ends idle on edge 3. nmi_wdog and int_irq act on the first edge.
- R6: Setting a bit in ext_mask or int_mask (1 = masked) stops the matching request from ending idle.
- R7: Address 1 holds three disable bits. Bit 1 blocks the maskable group, bit 2 blocks nmi_pin and bit 3 blocks nmi_wdog. A blocked source cannot end idle.
- R8: wdog_rst_req has no effect; an idle block stays idle.
- R9: On the wake edge, state_o becomes 3'b001 and both gated enables become 1. wake_o pulses for one cycle. The stop bit clears, so the block does not enter idle again until software writes the stop bit again.
- R10: A non-maskable wake sets wake_nmi_o and wake_ack_o, whatever int_en and the priorities are.
- R11: A maskable-only wake sets wake_ack_o only when int_en is 1 and either isr_active is 0 or pend_prio > isr_level (a larger value is more urgent). Otherwise the request stays pending and wake_ack_o is 0.
- R12: An enabled wake source seen during the entering state aborts the entry and returns the block to normal state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = mode register, 1 = control register |
| wr_data | input | 4 | Write data |
| nmi_pin | input | 1 | Asynchronous non-maskable pin request |
| nmi_wdog | input | 1 | Synchronous watchdog non-maskable request |
| ext_irq | input | 8 | Asynchronous external interrupt pins |
| ext_mask | input | 8 | External masks, 1 = masked |
| int_irq | input | 4 | Internal peripheral requests |
| int_mask | input | 4 | Internal masks, 1 = masked |
| int_en | input | 1 | CPU interrupt enable |
| isr_active | input | 1 | An interrupt is being serviced |
| isr_level | input | 3 | Priority of the serviced interrupt |
| pend_prio | input | 3 | Priority of the highest pending maskable request |
| wdog_rst_req | input | 1 | Watchdog reset request, ignored |
| osc_run_o | output | 1 | Oscillator keep-running |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| per_clk_en_o | output | 1 | Main-clock peripheral enable |
| aux_clk_en_o | output | 1 | Secondary-clock peripheral enable |
| state_o | output | 3 | One-hot state: 001 normal, 010 entering, 100 idle |
| wake_o | output | 1 | One-cycle wake pulse |
| wake_ack_o | output | 1 | Acknowledge the waking request |
| wake_nmi_o | output | 1 | The wake came from a non-maskable source |

## Verification
The hardest situation to reach is a wake that lands in the two-cycle entering window. The stimulus reaches it by raising the watchdog request exactly one edge after the block leaves normal state, which checks the abort path in R12. Blocking by masks and disable bits is shown by holding the blocked sources high for several cycles while idle, then waking through a different, enabled source. The acknowledge decision is covered by waking with pending priorities on either side of the in-service level, and with interrupts disabled.

// File: rtl/idle_pkg.sv
package idle_pkg;
  typedef enum logic [2:0] {
    ST_RUN   = 3'b001,
    ST_ENTER = 3'b010,
    ST_IDLE  = 3'b100
  } pwr_state_e;

  localparam int WDAT_W       = 4;
  localparam int BIT_STOP     = 0;
  localparam int BIT_DIS_MASK = 1;
  localparam int BIT_DIS_NPIN = 2;
  localparam int BIT_DIS_NWDG = 3;
  localparam int BIT_MODE     = 0;
  localparam logic ADDR_MODE  = 1'b0;
  localparam logic ADDR_CTRL  = 1'b1;
endpackage

// File: rtl/idle_rst_sync.sv
module idle_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_n_o = s2_q;
endmodule

// File: rtl/idle_sync.sv
module idle_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
      end else begin
        s1_q <= d_i[g];
        s2_q <= s1_q;
      end
    end
    assign q_o[g] = s2_q;
  end
endmodule

// File: rtl/idle_regs.sv
module idle_regs
  import idle_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [WDAT_W-1:0] wr_data,
  input  logic              in_run_i,
  input  logic              wake_i,
  output logic              mode_q,
  output logic              stop_q,
  output logic              dis_mask_q,
  output logic              dis_npin_q,
  output logic              dis_nwdg_q
);
  logic mode_d, stop_d, dis_mask_d, dis_npin_d, dis_nwdg_d;
  logic wr_mode, wr_ctrl, stop_req;

  always_comb begin
    wr_mode    = wr_en && (wr_addr == ADDR_MODE);
    wr_ctrl    = wr_en && (wr_addr == ADDR_CTRL);
    stop_req   = wr_ctrl && wr_data[BIT_STOP] && in_run_i && !mode_q;
    mode_d     = wr_mode ? wr_data[BIT_MODE] : mode_q;
    dis_mask_d = wr_ctrl ? wr_data[BIT_DIS_MASK] : dis_mask_q;
    dis_npin_d = wr_ctrl ? wr_data[BIT_DIS_NPIN] : dis_npin_q;
    dis_nwdg_d = wr_ctrl ? wr_data[BIT_DIS_NWDG] : dis_nwdg_q;
    if (wake_i)        stop_d = 1'b0;
    else if (stop_req) stop_d = 1'b1;
    else               stop_d = stop_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= 1'b0;
      stop_q     <= 1'b0;
      dis_mask_q <= 1'b0;
      dis_npin_q <= 1'b0;
      dis_nwdg_q <= 1'b0;
    end else begin
      mode_q     <= mode_d;
      stop_q     <= stop_d;
      dis_mask_q <= dis_mask_d;
      dis_npin_q <= dis_npin_d;
      dis_nwdg_q <= dis_nwdg_d;
    end
  end

  // R9
  stop_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_i |=> !stop_q);

  // R3
  mode_blk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_CTRL && mode_q && !stop_q) |=> !stop_q);
endmodule

// File: rtl/idle_wake_eval.sv
module idle_wake_eval #(
  parameter int N_EXT  = 8,
  parameter int N_INT  = 4,
  parameter int PRIO_W = 3
) (
  input  logic              armed_i,
  input  logic              nmi_pin_s_i,
  input  logic              nmi_wdog_i,
  input  logic [N_EXT-1:0]  ext_s_i,
  input  logic [N_EXT-1:0]  ext_mask_i,
  input  logic [N_INT-1:0]  int_irq_i,
  input  logic [N_INT-1:0]  int_mask_i,
  input  logic              dis_mask_i,
  input  logic              dis_npin_i,
  input  logic              dis_nwdg_i,
  input  logic              int_en_i,
  input  logic              isr_active_i,
  input  logic [PRIO_W-1:0] isr_level_i,
  input  logic [PRIO_W-1:0] pend_prio_i,
  output logic              wake_any_o,
  output logic              wake_nmi_o,
  output logic              wake_ack_o
);
  logic nmi_hit, mask_hit, prio_wins;
  logic [N_EXT-1:0] ext_live;
  logic [N_INT-1:0] int_live;

  always_comb begin
    ext_live   = ext_s_i & ~ext_mask_i;
    int_live   = int_irq_i & ~int_mask_i;
    nmi_hit    = (nmi_pin_s_i && !dis_npin_i) || (nmi_wdog_i && !dis_nwdg_i);
    mask_hit   = !dis_mask_i && ((|ext_live) || (|int_live));
    prio_wins  = !isr_active_i || (pend_prio_i > isr_level_i);
    wake_any_o = armed_i && (nmi_hit || mask_hit);
    wake_nmi_o = wake_any_o && nmi_hit;
    wake_ack_o = wake_any_o && (nmi_hit || (int_en_i && prio_wins));
  end
endmodule

// File: rtl/idle_fsm.sv
module idle_fsm
  import idle_pkg::*;
#(
  parameter int ENTRY_CYC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stop_i,
  input  logic       wake_any_i,
  input  logic       wake_nmi_i,
  input  logic       wake_ack_i,
  output pwr_state_e state_o,
  output logic       cpu_en_o,
  output logic       per_en_o,
  output logic       wake_o,
  output logic       wake_nmi_o,
  output logic       wake_ack_o
);
  localparam int CNT_W = (ENTRY_CYC > 1) ? $clog2(ENTRY_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(ENTRY_CYC - 1);

  pwr_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic cpu_en_q, per_en_q, gate_d;
  logic wake_q, wake_nmi_q, wake_ack_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_RUN: begin
        if (stop_i) begin
          state_d = ST_ENTER;
          cnt_d   = CNT_LOAD;
        end
      end
      ST_ENTER: begin
        if (wake_any_i)          state_d = ST_RUN;
        else if (cnt_q == '0)    state_d = ST_IDLE;
        else                     cnt_d   = cnt_q - 1'b1;
      end
      ST_IDLE: begin
        if (wake_any_i) state_d = ST_RUN;
      end
      default: state_d = ST_RUN;
    endcase
    gate_d = (state_d == ST_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_RUN;
      cnt_q      <= '0;
      cpu_en_q   <= 1'b1;
      per_en_q   <= 1'b1;
      wake_q     <= 1'b0;
      wake_nmi_q <= 1'b0;
      wake_ack_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      cnt_q      <= cnt_d;
      cpu_en_q   <= !gate_d;
      per_en_q   <= !gate_d;
      wake_q     <= wake_any_i;
      wake_nmi_q <= wake_nmi_i;
      wake_ack_q <= wake_ack_i;
    end
  end

  assign state_o    = state_q;
  assign cpu_en_o   = cpu_en_q;
  assign per_en_o   = per_en_q;
  assign wake_o     = wake_q;
  assign wake_nmi_o = wake_nmi_q;
  assign wake_ack_o = wake_ack_q;

  // R2
  enter_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_q == ST_IDLE) |-> $past(state_q == ST_ENTER));

  // R4
  idle_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> (!cpu_en_q && !per_en_q));

  // R9
  wake_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_q |-> (state_q == ST_RUN && cpu_en_q && per_en_q));

  // R10
  nmi_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_nmi_q |-> wake_ack_q);
endmodule

// File: rtl/idle_wake_ctrl.sv
module idle_wake_ctrl
  import idle_pkg::*;
#(
  parameter int N_EXT     = 8,
  parameter int N_INT     = 4,
  parameter int PRIO_W    = 3,
  parameter int ENTRY_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [WDAT_W-1:0] wr_data,
  input  logic              nmi_pin,
  input  logic              nmi_wdog,
  input  logic [N_EXT-1:0]  ext_irq,
  input  logic [N_EXT-1:0]  ext_mask,
  input  logic [N_INT-1:0]  int_irq,
  input  logic [N_INT-1:0]  int_mask,
  input  logic              int_en,
  input  logic              isr_active,
  input  logic [PRIO_W-1:0] isr_level,
  input  logic [PRIO_W-1:0] pend_prio,
  input  logic              wdog_rst_req,
  output logic              osc_run_o,
  output logic              cpu_clk_en_o,
  output logic              per_clk_en_o,
  output logic              aux_clk_en_o,
  output logic [2:0]        state_o,
  output logic              wake_o,
  output logic              wake_ack_o,
  output logic              wake_nmi_o
);
  logic rst_int_n;
  logic nmi_pin_s;
  logic [N_EXT-1:0] ext_s;
  logic mode_q, stop_q, dis_mask_q, dis_npin_q, dis_nwdg_q;
  logic wake_any, wake_nmi, wake_ack;
  pwr_state_e state;

  idle_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_int_n)
  );

  idle_sync #(.W(1)) u_sync_nmi (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d_i   (nmi_pin),
    .q_o   (nmi_pin_s)
  );

  idle_sync #(.W(N_EXT)) u_sync_ext (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d_i   (ext_irq),
    .q_o   (ext_s)
  );

  idle_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .in_run_i   (state == ST_RUN),
    .wake_i     (wake_any),
    .mode_q     (mode_q),
    .stop_q     (stop_q),
    .dis_mask_q (dis_mask_q),
    .dis_npin_q (dis_npin_q),
    .dis_nwdg_q (dis_nwdg_q)
  );

  idle_wake_eval #(.N_EXT(N_EXT), .N_INT(N_INT), .PRIO_W(PRIO_W)) u_eval (
    .armed_i      (state != ST_RUN),
    .nmi_pin_s_i  (nmi_pin_s),
    .nmi_wdog_i   (nmi_wdog),
    .ext_s_i      (ext_s),
    .ext_mask_i   (ext_mask),
    .int_irq_i    (int_irq),
    .int_mask_i   (int_mask),
    .dis_mask_i   (dis_mask_q),
    .dis_npin_i   (dis_npin_q),
    .dis_nwdg_i   (dis_nwdg_q),
    .int_en_i     (int_en),
    .isr_active_i (isr_active),
    .isr_level_i  (isr_level),
    .pend_prio_i  (pend_prio),
    .wake_any_o   (wake_any),
    .wake_nmi_o   (wake_nmi),
    .wake_ack_o   (wake_ack)
  );

  idle_fsm #(.ENTRY_CYC(ENTRY_CYC)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .stop_i     (stop_q),
    .wake_any_i (wake_any),
    .wake_nmi_i (wake_nmi),
    .wake_ack_i (wake_ack),
    .state_o    (state),
    .cpu_en_o   (cpu_clk_en_o),
    .per_en_o   (per_clk_en_o),
    .wake_o     (wake_o),
    .wake_nmi_o (wake_nmi_o),
    .wake_ack_o (wake_ack_o)
  );

  assign osc_run_o    = 1'b1;
  assign aux_clk_en_o = 1'b1;
  assign state_o      = state;

  // R8
  wdrst_ign_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state == ST_IDLE && wdog_rst_req && !wake_any) |=> (state == ST_IDLE));

  // R5
  sync_lat_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state == ST_IDLE && !nmi_wdog && (int_irq == '0) && !$past(nmi_pin) &&
     ($past(ext_irq) == '0)) |=> !wake_o || $past(nmi_pin_s) || ($past(ext_s) != '0));
endmodule

// File: tb/test_idle_wake_ctrl.sv
`timescale 1ns/1ps
module test_idle_wake_ctrl;
  localparam int ENTRY = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic wr_en, wr_addr;
  logic [3:0] wr_data;
  logic nmi_pin, nmi_wdog, int_en, isr_active, wdog_rst_req;
  logic [7:0] ext_irq, ext_mask;
  logic [3:0] int_irq, int_mask;
  logic [2:0] isr_level, pend_prio;
  logic osc_run_o, cpu_clk_en_o, per_clk_en_o, aux_clk_en_o;
  logic [2:0] state_o;
  logic wake_o, wake_ack_o, wake_nmi_o;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;

  idle_wake_ctrl i_idle_wake_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .nmi_pin(nmi_pin), .nmi_wdog(nmi_wdog), .ext_irq(ext_irq), .ext_mask(ext_mask),
    .int_irq(int_irq), .int_mask(int_mask), .int_en(int_en), .isr_active(isr_active),
    .isr_level(isr_level), .pend_prio(pend_prio), .wdog_rst_req(wdog_rst_req),
    .osc_run_o(osc_run_o), .cpu_clk_en_o(cpu_clk_en_o), .per_clk_en_o(per_clk_en_o),
    .aux_clk_en_o(aux_clk_en_o), .state_o(state_o), .wake_o(wake_o),
    .wake_ack_o(wake_ack_o), .wake_nmi_o(wake_nmi_o)
  );

  // behavioural reference model
  bit m_rs1, m_rs2, m_p1, m_p2, m_mode, m_stop, m_dm, m_dp, m_dw;
  bit m_wk, m_ack, m_nm;
  logic [7:0] m_e1, m_e2;
  int m_st, m_cnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rs1 = 0; m_rs2 = 0; m_p1 = 0; m_p2 = 0; m_e1 = '0; m_e2 = '0;
      m_mode = 0; m_stop = 0; m_dm = 0; m_dp = 0; m_dw = 0;
      m_wk = 0; m_ack = 0; m_nm = 0; m_st = 0; m_cnt = 0;
    end else if (!m_rs2) begin
      m_rs2 = m_rs1; m_rs1 = 1;
    end else begin
      bit nmi_s, wn, wm, wake, ackok, old_mode;
      logic [7:0] ext_s;
      int old_st;
      nmi_s = m_p2; ext_s = m_e2;
      m_p2 = m_p1; m_p1 = nmi_pin; m_e2 = m_e1; m_e1 = ext_irq;
      wn = (!m_dp && nmi_s) || (!m_dw && nmi_wdog);
      wm = !m_dm && (((ext_s & ~ext_mask) != 0) || ((int_irq & ~int_mask) != 0));
      wake = (m_st != 0) && (wn || wm);
      ackok = wn || (int_en && (!isr_active || pend_prio > isr_level));
      m_wk = wake; m_nm = wake && wn; m_ack = wake && ackok;
      old_st = m_st; old_mode = m_mode;
      case (m_st)
        0: if (m_stop) begin m_st = 1; m_cnt = ENTRY - 1; end
        1: if (wake) m_st = 0; else if (m_cnt == 0) m_st = 2; else m_cnt--;
        default: if (wake) m_st = 0;
      endcase
      if (wr_en && !wr_addr) m_mode = wr_data[0];
      if (wr_en && wr_addr) begin m_dm = wr_data[1]; m_dp = wr_data[2]; m_dw = wr_data[3]; end
      if (wake) m_stop = 0;
      else if (wr_en && wr_addr && wr_data[0] && old_st == 0 && !old_mode) m_stop = 1;
    end
  end

  task automatic cmp(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    #5;
    if (!done) begin
      cmp("R2 state_o", state_o, (m_st == 0) ? 1 : (m_st == 1) ? 2 : 4);
      cmp("R4 cpu_clk_en_o", cpu_clk_en_o, m_st != 2);
      cmp("R4 per_clk_en_o", per_clk_en_o, m_st != 2);
      cmp("R4 osc_run_o", osc_run_o, 1);
      cmp("R4 aux_clk_en_o", aux_clk_en_o, 1);
      cmp("R9 wake_o", wake_o, m_wk);
      cmp("R11 wake_ack_o", wake_ack_o, m_ack);
      cmp("R10 wake_nmi_o", wake_nmi_o, m_nm);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic wr(input logic a, input logic [3:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0; wr_data = '0;
  endtask

  task automatic go_idle(input logic [3:0] d);
    wr(1'b1, d);
    repeat (3) @(negedge clk);
    cmp("R2 idle after four edges", state_o, 4);
  endtask

  initial begin
    rst_n = 0; wr_en = 0; wr_addr = 0; wr_data = '0;
    nmi_pin = 0; nmi_wdog = 0; int_en = 0; isr_active = 0; wdog_rst_req = 0;
    ext_irq = '0; ext_mask = '0; int_irq = '0; int_mask = '0;
    isr_level = '0; pend_prio = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    cmp("R1 reset state", state_o, 1);
    cmp("R1 reset cpu enable", cpu_clk_en_o, 1);
    cmp("R1 reset wake", wake_o, 0);

    // external pin wake, watchdog reset ignored
    go_idle(4'h1);
    wdog_rst_req = 1;
    repeat (3) @(negedge clk);
    wdog_rst_req = 0;
    cmp("R8 wdog reset ignored", state_o, 4);
    ext_irq[3] = 1;
    repeat (2) @(negedge clk);
    cmp("R5 still idle during sync", state_o, 4);
    @(negedge clk);
    cmp("R5 woke on third edge", state_o, 1);
    cmp("R9 wake pulse", wake_o, 1);
    cmp("R11 no ack with int_en=0", wake_ack_o, 0);
    ext_irq = '0;
    repeat (4) @(negedge clk);
    cmp("R9 stop cleared, stays normal", state_o, 1);

    // masked pin, then low-priority internal wake
    ext_mask = 8'h04; ext_irq[2] = 1;
    go_idle(4'h1);
    repeat (5) @(negedge clk);
    cmp("R6 masked pin ignored", state_o, 4);
    int_en = 1; isr_active = 1; isr_level = 3'd5; pend_prio = 3'd2; int_irq = 4'b0010;
    @(negedge clk);
    cmp("R11 low prio wakes", state_o, 1);
    cmp("R11 low prio not acked", wake_ack_o, 0);
    int_irq = '0; ext_irq = '0; ext_mask = '0;
    repeat (4) @(negedge clk);

    // high-priority internal wake
    pend_prio = 3'd6;
    go_idle(4'h1);
    int_irq = 4'b0010;
    @(negedge clk);
    cmp("R11 high prio acked", wake_ack_o, 1);
    cmp("R10 maskable not nmi", wake_nmi_o, 0);
    int_irq = '0;
    repeat (2) @(negedge clk);

    // maskable group disabled, watchdog nmi wakes
    go_idle(4'h3);
    int_irq = 4'b0001;
    repeat (4) @(negedge clk);
    cmp("R7 maskable disabled", state_o, 4);
    int_irq = '0; int_en = 0; nmi_wdog = 1;
    @(negedge clk);
    cmp("R10 nmi flag", wake_nmi_o, 1);
    cmp("R10 nmi ack with int_en=0", wake_ack_o, 1);
    nmi_wdog = 0;
    repeat (2) @(negedge clk);

    // both nmi sources disabled
    go_idle(4'hD);
    nmi_pin = 1; nmi_wdog = 1;
    repeat (5) @(negedge clk);
    cmp("R7 nmi sources disabled", state_o, 4);
    nmi_pin = 0; nmi_wdog = 0; int_irq = 4'b1000;
    @(negedge clk);
    cmp("R9 internal wake", state_o, 1);
    int_irq = '0;
    repeat (3) @(negedge clk);

    // mode bit blocks entry
    wr(1'b0, 4'h1);
    wr(1'b1, 4'h1);
    repeat (4) @(negedge clk);
    cmp("R3 mode bit blocks stop", state_o, 1);
    wr(1'b0, 4'h0);

    // wake during entering
    wr(1'b1, 4'h1);
    @(negedge clk);
    cmp("R12 entering", state_o, 2);
    nmi_wdog = 1;
    @(negedge clk);
    cmp("R12 abort to normal", state_o, 1);
    nmi_wdog = 0;
    repeat (3) @(negedge clk);
    cmp("R12 stays normal", state_o, 1);

    // nmi pin wake
    go_idle(4'h1);
    nmi_pin = 1;
    repeat (3) @(negedge clk);
    cmp("R5 nmi pin woke", state_o, 1);
    cmp("R10 nmi pin flag", wake_nmi_o, 1);
    nmi_pin = 0;
    repeat (3) @(negedge clk);

    // reset while idle
    go_idle(4'h1);
    rst_n = 0;
    @(negedge clk);
    cmp("R1 reset from idle", state_o, 1);
    cmp("R1 reset enables clock", cpu_clk_en_o, 1);
    rst_n = 1;
    repeat (4) @(negedge clk);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule